// File: doc/BRIEF.md
# Local Interrupt Timer With Divider

This block is a 32-bit down-counter that a processor core uses as its private tick source. Software programs a clock prescaler and a control word holding an interrupt vector, a mask and a mode. Writing a start value then loads the counter and sets it running. Each enabled tick of the prescaled clock takes one off the count. When the count reaches zero, the block emits a single-cycle interrupt request carrying the programmed vector, unless the request is masked.

In periodic mode the counter reloads from the stored start value and keeps going. In one-shot mode it parks at zero. Because the running count can be read back, software can calibrate the tick rate: it writes the all-ones start value, waits a known time and subtracts the count it reads.

All registers sit on a simple word bus. Writes take effect on the clock edge where the write strobe is high. Reads return data combinationally from the address.

Top module: `lit_timer`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (masked, one-shot, vector 0), and the start value, the running count and the prescaler code all read 0. No interrupt is raised.
- R2: Register offsets are control word 0x320, start value 0x380, running count 0x390 and prescaler code 0x3E0. In the control word, bits 7:0 hold the vector, bit 16 the mask, bit 17 the mode (1 = periodic) and bits 19:18 the clock source. All other control bits read 0, only bits 3:0 of the prescaler code are kept, and unmapped offsets read 0.
- R3: The running count at 0x390 is read-only, so a write to it leaves the count unchanged.
- R4: Writing a non-zero value N to the start value loads the running count with N, starts counting and restarts the prescaler phase. Writing again mid-run restarts the whole countdown.
- R5: The prescaler code selects the divisor. Codes 0x0, 0x1, 0x2 and 0x3 give 2, 4, 8 and 16. Codes 0x8, 0x9 and 0xA give 32, 64 and 128, and 0xB gives 1. Bit 2 of the code is ignored. With divisor D and start value N, the interrupt appears D*N cycles after the write edge.
- R6: In one-shot mode the count stops at 0 after expiry and no further request follows.
- R7: In periodic mode the count reloads from the start value on expiry, giving a request every D*N cycles.
- R8: A request is a one-clock pulse on `irq_valid` with the vector on `irq_vector`. `irq_vector` reads 0 whenever `irq_valid` is low.
- R9: With the mask set, no request is produced, but the count keeps decrementing and reloading.
- R10: Writing a start value of 0 stops the timer and sets the running count to 0, and no request follows.
- R11: A non-zero clock-source field (bits 19:18) freezes the count. Counting resumes when the field returns to 00.
- R12: After the all-ones start value is written with divisor 1, the running count read K cycles later equals 0xFFFF_FFFF minus K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the raw timer input |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector carried by the request |

## Verification
A wrong prescaler phase or a wrong decode of the prescaler code shifts the expiry pulse by whole prescaler periods. The bench counts cycles from the write edge, so such a fault shows at the first expiry. A counter that fails to reload, stop or freeze shows at once in the running count read back at 0x390, or as a missing or extra pulse within one period. A fault in the mask or vector path shows as a pulse, or as a vector value, in the very cycle the count reaches zero.

// File: rtl/lit_pkg.sv
package lit_pkg;

    localparam logic [11:0] OFS_CTRL  = 12'h320;
    localparam logic [11:0] OFS_START = 12'h380;
    localparam logic [11:0] OFS_COUNT = 12'h390;
    localparam logic [11:0] OFS_PRESC = 12'h3E0;

    localparam int CTRL_VEC_LSB = 0;
    localparam int CTRL_MASK    = 16;
    localparam int CTRL_MODE    = 17;
    localparam int CTRL_SRC_LSB = 18;

    localparam int SHIFT_W = 3;

    typedef struct packed {
        logic [1:0] src;
        logic       periodic;
        logic       masked;
        logic [7:0] vector;
    } ctrl_t;

    // codes map {b3,b1,b0}+1 mod 8 onto log2 of the divisor
    function automatic logic [SHIFT_W-1:0] presc_shift(input logic [3:0] code);
        return {code[3], code[1:0]} + 3'd1;
    endfunction

endpackage

// File: rtl/lit_prescaler.sv
module lit_prescaler
    import lit_pkg::*;
#(
    parameter int PRE_W = (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    logic [PRE_W-1:0] phase_d, phase_q;
    logic [PRE_W-1:0] low_ones;

    always_comb begin
        low_ones = PRE_W'((1 << shift) - 1);
        tick     = (phase_q & low_ones) == low_ones;
        phase_d  = restart ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

endmodule

// File: rtl/lit_regs.sv
module lit_regs
    import lit_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cur_count,
    output logic [CNT_W-1:0]  rdata,
    output logic [CNT_W-1:0]  start_val,
    output logic [3:0]        presc_code,
    output ctrl_t             ctrl,
    output logic              load
);

    typedef struct packed {
        logic [CNT_W-1:0] start;
        logic [3:0]       presc;
        ctrl_t            ctrl;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_ctrl, hit_start, hit_presc;

    always_comb begin
        hit_ctrl  = addr == ADDR_W'(OFS_CTRL);
        hit_start = addr == ADDR_W'(OFS_START);
        hit_presc = addr == ADDR_W'(OFS_PRESC);

        r_d = r_q;
        if (we && hit_start) r_d.start = wdata;
        if (we && hit_presc) r_d.presc = wdata[3:0];
        if (we && hit_ctrl) begin
            r_d.ctrl.vector   = wdata[CTRL_VEC_LSB +: 8];
            r_d.ctrl.masked   = wdata[CTRL_MASK];
            r_d.ctrl.periodic = wdata[CTRL_MODE];
            r_d.ctrl.src      = wdata[CTRL_SRC_LSB +: 2];
        end
        load = we && hit_start;

        rdata = '0;
        if (hit_ctrl) begin
            rdata[CTRL_VEC_LSB +: 8] = r_q.ctrl.vector;
            rdata[CTRL_MASK]         = r_q.ctrl.masked;
            rdata[CTRL_MODE]         = r_q.ctrl.periodic;
            rdata[CTRL_SRC_LSB +: 2] = r_q.ctrl.src;
        end else if (hit_start) begin
            rdata = r_q.start;
        end else if (addr == ADDR_W'(OFS_COUNT)) begin
            rdata = cur_count;
        end else if (hit_presc) begin
            rdata[3:0] = r_q.presc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q             <= '0;
            r_q.ctrl.masked <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_val  = r_q.start;
    assign presc_code = r_q.presc;
    assign ctrl       = r_q.ctrl;

endmodule

// File: rtl/lit_counter.sv
module lit_counter #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  logic             src_ok,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] cur,
    output logic             running,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        c_d.vec = '0;
        if (load) begin
            c_d.cnt = load_val;
            c_d.run = load_val != '0;
        end else if (c_q.run && tick && src_ok) begin
            if (c_q.cnt == CNT_W'(1)) begin
                if (!masked) begin
                    c_d.irq = 1'b1;
                    c_d.vec = vector;
                end
                if (periodic) begin
                    c_d.cnt = reload_val;
                end else begin
                    c_d.cnt = '0;
                    c_d.run = 1'b0;
                end
            end else begin
                c_d.cnt = c_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cur        = c_q.cnt;
    assign running    = c_q.run;
    assign irq_valid  = c_q.irq;
    assign irq_vector = c_q.vec;

endmodule

// File: rtl/lit_timer.sv
module lit_timer
    import lit_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] cur;
    logic [3:0]       presc_code;
    ctrl_t            ctrl;
    logic             load;
    logic             tick;
    logic             running;
    logic             src_ok;

    lit_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .cur_count  (cur),
        .rdata      (reg_rdata),
        .start_val  (start_val),
        .presc_code (presc_code),
        .ctrl       (ctrl),
        .load       (load)
    );

    lit_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .shift   (presc_shift(presc_code)),
        .tick    (tick)
    );

    assign src_ok = ctrl.src == 2'b00;

    lit_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (reg_wdata),
        .reload_val (start_val),
        .tick       (tick),
        .src_ok     (src_ok),
        .periodic   (ctrl.periodic),
        .masked     (ctrl.masked),
        .vector     (VEC_W'(ctrl.vector)),
        .cur        (cur),
        .running    (running),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

endmodule

// File: rtl/lit_timer_chk.sv
module lit_timer_chk #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] start_val,
    input logic [CNT_W-1:0] cur,
    input logic             running,
    input logic             tick,
    input logic             src_ok,
    input logic             periodic,
    input logic             masked,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vector
);

    logic expire;
    assign expire = running && tick && src_ok && !load && cur == CNT_W'(1);

    a_r4_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> (cur == $past(load_val) && running));

    a_r10_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (cur == '0 && !running));

    a_r6_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic) |=> (cur == '0 && !running));

    a_r7_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> (cur == $past(start_val) && running));

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(masked));

    a_r8_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> irq_vector == '0);

    a_r11_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (!running || !src_ok)) |=> $stable(cur));

endmodule

bind lit_timer lit_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_val   (reg_wdata),
    .start_val  (start_val),
    .cur        (cur),
    .running    (running),
    .tick       (tick),
    .src_ok     (src_ok),
    .periodic   (ctrl.periodic),
    .masked     (ctrl.masked),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector)
);

// File: tb/lit_timer_tb.sv
`timescale 1ns/1ps
module lit_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    lit_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    // {prescaler code, start value, expected cycles to expiry}
    localparam logic [23:0] VECS [10] = '{
        {4'hB, 8'd5, 12'd5},   {4'h0, 8'd3, 12'd6},
        {4'h1, 8'd2, 12'd8},   {4'h2, 8'd2, 12'd16},
        {4'h3, 8'd1, 12'd16},  {4'h8, 8'd1, 12'd32},
        {4'h9, 8'd1, 12'd64},  {4'hA, 8'd2, 12'd256},
        {4'h4, 8'd3, 12'd6},   {4'hF, 8'd4, 12'd4}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wait_irq(input int limit, output int cyc, output bit found,
                            output logic [7:0] vec);
        cyc = 0; found = 0; vec = '0;
        while (cyc < limit && !found) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (irq_valid) begin
                found = 1;
                vec = irq_vector;
            end
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
        summary();
    end

    initial begin
        logic [31:0] v;
        int          cyc;
        bit          found;
        logic [7:0]  vec;
        int          pulses;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h320, v); chk(v == 32'h0001_0000, "R1", "ctrl reset", v, 32'h0001_0000);
        rd(12'h380, v); chk(v == 0, "R1", "start reset", v, 0);
        rd(12'h390, v); chk(v == 0, "R1", "count reset", v, 0);
        rd(12'h3E0, v); chk(v == 0, "R1", "presc reset", v, 0);
        chk(!irq_valid, "R1", "irq reset", 32'(irq_valid), 0);

        // R2 field layout and unmapped offsets
        wr(12'h320, 32'hFFFF_FFFF);
        rd(12'h320, v); chk(v == 32'h000F_00FF, "R2", "ctrl fields", v, 32'h000F_00FF);
        wr(12'h3E0, 32'hFFFF_FFF3);
        rd(12'h3E0, v); chk(v == 32'h3, "R2", "presc bits", v, 32'h3);
        rd(12'h3F0, v); chk(v == 0, "R2", "unmapped", v, 0);

        // R5 R6 R8 table of divisor vectors, one-shot unmasked
        for (int i = 0; i < 10; i++) begin
            logic [3:0]  code;
            logic [7:0]  n;
            logic [11:0] exp;
            {code, n, exp} = VECS[i];
            wr(12'h3E0, 32'(code));
            wr(12'h320, 32'h40 + 32'(i));
            wr(12'h380, 32'(n));
            wait_irq(int'(exp) + 8, cyc, found, vec);
            chk(found && cyc == int'(exp), "R5", "expiry cycle", 32'(cyc), 32'(exp));
            chk(vec == 8'(8'h40 + i), "R8", "vector", 32'(vec), 32'h40 + 32'(i));
            @(posedge clk); @(negedge clk);
            chk(!irq_valid && irq_vector == 0, "R8", "pulse width", 32'(irq_valid), 0);
            rd(12'h390, v); chk(v == 0, "R6", "parked count", v, 0);
            wait_irq(40, cyc, found, vec);
            chk(!found, "R6", "no refire", 32'(found), 0);
        end

        // R3 count is read-only
        wr(12'h3E0, 32'hB);
        wr(12'h390, 32'h1234);
        rd(12'h390, v); chk(v == 0, "R3", "count write ignored", v, 0);

        // R7 periodic, divisor 1, N=3
        wr(12'h320, 32'h0002_0055);
        wr(12'h380, 32'd3);
        pulses = 0;
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk); @(negedge clk);
            if (irq_valid) pulses++;
            chk(irq_valid == (k % 3 == 0), "R7", "periodic pulse", 32'(irq_valid), 32'(k % 3 == 0));
            if (!irq_valid) chk(irq_vector == 0, "R8", "idle vector", 32'(irq_vector), 0);
        end
        chk(pulses == 4, "R7", "pulse count", 32'(pulses), 4);

        // R9 masked periodic keeps counting
        wr(12'h320, 32'h0003_0055);
        wr(12'h380, 32'd4);
        for (int k = 1; k <= 9; k++) begin
            @(posedge clk); @(negedge clk);
            chk(!irq_valid, "R9", "masked silent", 32'(irq_valid), 0);
            rd(12'h390, v);
            chk(v == 32'(4 - (k % 4)), "R9", "masked count", v, 32'(4 - (k % 4)));
        end

        // R10 zero start stops
        wr(12'h320, 32'h0000_0066);
        wr(12'h380, 32'd100);
        repeat (5) @(posedge clk);
        wr(12'h380, 32'd0);
        rd(12'h390, v); chk(v == 0, "R10", "count zeroed", v, 0);
        wait_irq(150, cyc, found, vec);
        chk(!found, "R10", "no request", 32'(found), 0);

        // R11 non-raw clock source freezes count
        wr(12'h320, 32'h0004_0077);
        wr(12'h380, 32'd10);
        wait_irq(20, cyc, found, vec);
        chk(!found, "R11", "frozen no irq", 32'(found), 0);
        rd(12'h390, v); chk(v == 10, "R11", "frozen count", v, 10);
        wr(12'h320, 32'h0000_0077);
        wait_irq(20, cyc, found, vec);
        chk(found && cyc == 10, "R11", "resume expiry", 32'(cyc), 10);

        // R4 restart mid-run with divisor 2
        wr(12'h3E0, 32'h0);
        wr(12'h380, 32'd10);
        repeat (7) @(posedge clk);
        wr(12'h380, 32'd10);
        wait_irq(40, cyc, found, vec);
        chk(found && cyc == 20, "R4", "restart expiry", 32'(cyc), 20);

        // R12 calibration readback
        wr(12'h3E0, 32'hB);
        wr(12'h380, 32'hFFFF_FFFF);
        repeat (37) @(posedge clk);
        @(negedge clk);
        rd(12'h390, v);
        chk(v == 32'hFFFF_FFFF - 37, "R12", "elapsed", v, 32'hFFFF_FFFF - 37);
        wr(12'h380, 32'd0);

        summary();
    end

endmodule